// File: doc/BRIEF.md
# Atomic Pin Output and Direction Register Bank

This block holds the software-owned drive level and drive direction for a bank of 30 pins. The block has one register for each. Software can overwrite either register in a single write. It can also update either one through three alias addresses: one forces masked bits to 1, one forces them to 0, and one inverts them. Because of these aliases, several agents can change different pins without a read-modify-write race.

The same register port also returns the pad input word, captured through a two-stage synchroniser. It can read back the stored drive level and direction, and that read is independent of what the pads currently show. The stored registers drive the `pin_out` and `pin_oe` vectors directly. A 1 in `pin_oe` means the pin drives, and a 0 means it is an input.

The register port has one cycle of write latency and combinational reads. It decodes the following word addresses:
- 0: input word
- 1: output register, direct write
- 2: output register, set alias
- 3: output register, clear alias
- 4: output register, toggle alias
- 5: direction register, direct write
- 6: direction register, set alias
- 7: direction register, clear alias
- 8: direction register, toggle alias

Every other address is unmapped.

Top module: `pin_drive_regs`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the output register, the direction register and the synchroniser are all zero, so `pin_out` and `pin_oe` are zero.
- R2: A write to address 1 replaces bits [29:0] of the output register with `wdata[29:0]` from the next clock edge on.
- R3: A write to address 2 sets to 1 every output bit whose `wdata` bit is 1 and leaves every other bit unchanged.
- R4: A write to address 3 clears to 0 every output bit whose `wdata` bit is 1 and leaves every other bit unchanged.
- R5: A write to address 4 inverts every output bit whose `wdata` bit is 1 and leaves every other bit unchanged.
- R6: Addresses 5, 6, 7 and 8 act on the direction register in the same way that addresses 1 to 4 act on the output register, and `pin_oe` follows the direction register.
- R7: A write to any output address (1 to 4) leaves the direction register unchanged. A write to any direction address (5 to 8) leaves the output register unchanged. A write to address 0 or to an unmapped address changes neither register.
- R8: `rdata` bits [31:30] always read 0. Reads of the alias addresses (2, 3, 4, 6, 7, 8) and of unmapped addresses return 0.
- R9: A read of address 1 returns the stored drive level, whatever `pin_in` is. A read of address 5 returns the stored direction.
- R10: A read of address 0 returns the value that `pin_in` had two rising edges earlier, so the input passes through two register stages.
- R11: When no register write is made, `pin_out` and `pin_oe` hold their values from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address of the access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 32 | Write data or bit mask |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 30 | Raw pad input levels |
| pin_out | output | 30 | Drive levels to the pads |
| pin_oe | output | 30 | Drive enables to the pads, 1 = drive |

## Verification
The assertions take for granted that `addr`, `wr_en` and `wdata` are stable and known around each rising edge. They also assume that `rst_n` changes away from the edge, so that each write can be checked from the values present in the cycle before. The stimulus meets this by changing every input only on the falling clock edge. It drives `pin_in` with random words that are unrelated to the register traffic, so the assertions and the bench can both see that the stored drive level never picks up pad values. Unmapped addresses and the read-only input address also receive writes, so that the check of "nothing changes" on those writes has real traffic to test.

// File: rtl/pin_drive_regs.sv
module pin_drive_regs #(
  parameter int PINS        = 30,
  parameter int DW          = 32,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);

  localparam logic [AW-1:0] A_IN  = AW'(0);
  localparam logic [AW-1:0] A_OUT = AW'(1);
  localparam logic [AW-1:0] A_OE  = AW'(5);

  logic [1:0][PINS-1:0]           reg_q;
  logic [SYNC_STAGES-1:0][PINS-1:0] sync_q;
  logic [PINS-1:0]                mask;
  logic                           unused_upper;

  assign mask         = wdata[PINS-1:0];
  assign unused_upper = ^wdata[DW-1:PINS];

  for (genvar g = 0; g < 2; g++) begin : g_reg
    localparam logic [AW-1:0] BASE = AW'(1 + 4 * g);
    logic [PINS-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else if (wr_en) begin
        if (addr == BASE)               val_q <= mask;
        else if (addr == BASE + AW'(1)) val_q <= val_q | mask;
        else if (addr == BASE + AW'(2)) val_q <= val_q & ~mask;
        else if (addr == BASE + AW'(3)) val_q <= val_q ^ mask;
      end
    end

    assign reg_q[g] = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_out = reg_q[0];
  assign pin_oe  = reg_q[1];

  always_comb begin
    rdata = '0;
    case (addr)
      A_IN:    rdata[PINS-1:0] = sync_q[SYNC_STAGES-1];
      A_OUT:   rdata[PINS-1:0] = reg_q[0];
      A_OE:    rdata[PINS-1:0] = reg_q[1];
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/pin_drive_regs_chk.sv
module pin_drive_regs_chk #(
  parameter int PINS = 30,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   addr,
  input logic            wr_en,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe
);

  logic out_hit, oe_hit;
  assign out_hit = wr_en && addr >= AW'(1) && addr <= AW'(4);
  assign oe_hit  = wr_en && addr >= AW'(5) && addr <= AW'(8);

  assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1)) |=> pin_out == $past(wdata[PINS-1:0]));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) |=> pin_out == ($past(pin_out) | $past(wdata[PINS-1:0])));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3)) |=> pin_out == ($past(pin_out) & ~$past(wdata[PINS-1:0])));

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4)) |=> pin_out == ($past(pin_out) ^ $past(wdata[PINS-1:0])));

  assert_oe_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8)) |=> pin_oe == ($past(pin_oe) ^ $past(wdata[PINS-1:0])));

  assert_out_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |=> $stable(pin_oe));

  assert_oe_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_hit |=> $stable(pin_out));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:PINS] == '0);

  assert_alias_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != AW'(0) && addr != AW'(1) && addr != AW'(5)) |-> rdata == '0);

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(1)) |-> rdata[PINS-1:0] == pin_out);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind pin_drive_regs pin_drive_regs_chk #(.PINS(PINS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_pin_drive_regs.sv
module tb_pin_drive_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [29:0] pin_in = '0;
  logic [29:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [29:0] m_out = '0, m_oe = '0, h0 = '0, h1 = '0;

  pin_drive_regs dut (.*);

  always #2 clk = ~clk;

  always @(negedge clk) pin_in <= 30'($urandom);

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return {2'b00, h1};
      4'd1: return {2'b00, m_out};
      4'd5: return {2'b00, m_oe};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    case (a)
      4'd0: return "R10";
      4'd1, 4'd5: return "R9";
      default: return "R8";
    endcase
  endfunction

  function automatic string wr_tag(input logic r, input logic w, input logic [3:0] a, input bit oe_side);
    if (!r) return "R1";
    if (!w) return "R11";
    if (a == 4'd0 || a > 4'd8) return "R7";
    if (oe_side) return (a >= 4'd5) ? "R6" : "R7";
    case (a)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always begin
    logic        c_rst, c_wr;
    logic [3:0]  c_a;
    logic [29:0] c_m, c_in;
    @(posedge clk);
    c_rst = rst_n; c_wr = wr_en; c_a = addr; c_m = wdata[29:0]; c_in = pin_in;
    #1;
    if (!c_rst) begin
      m_out = '0; m_oe = '0; h0 = '0; h1 = '0;
    end else begin
      h1 = h0; h0 = c_in;
      if (c_wr) case (c_a)
        4'd1: m_out = c_m;
        4'd2: m_out = m_out | c_m;
        4'd3: m_out = m_out & ~c_m;
        4'd4: m_out = m_out ^ c_m;
        4'd5: m_oe = c_m;
        4'd6: m_oe = m_oe | c_m;
        4'd7: m_oe = m_oe & ~c_m;
        4'd8: m_oe = m_oe ^ c_m;
        default: ;
      endcase
    end
    check(wr_tag(c_rst, c_wr, c_a, 1'b0), "pin_out", {2'b00, pin_out}, {2'b00, m_out});
    check(wr_tag(c_rst, c_wr, c_a, 1'b1), "pin_oe", {2'b00, pin_oe}, {2'b00, m_oe});
    if (c_rst) check(rd_tag(addr), "rdata", rdata, exp_read(addr));
  end

  task automatic op(input logic w, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    op(0, 4'd1, 0);
    op(1, 4'd1, 32'hFFFF_FFFF);
    op(0, 4'd1, 0);
    op(1, 4'd3, 32'h0000_F0F0);
    op(1, 4'd2, 32'h0000_0003);
    op(1, 4'd4, 32'h3000_00FF);
    op(0, 4'd2, 0);
    op(1, 4'd5, 32'hC555_5555);
    op(1, 4'd6, 32'h0A00_0000);
    op(1, 4'd7, 32'h0000_0005);
    op(1, 4'd8, 32'h3FFF_FFFF);
    op(0, 4'd5, 0);
    op(1, 4'd0, 32'h1234_5678);
    op(1, 4'd12, 32'hFFFF_FFFF);
    op(1, 4'd15, 32'hFFFF_FFFF);
    for (int a = 0; a < 16; a++) op(0, 4'(a), 32'hDEAD_BEEF);
    repeat (6) op(0, 4'd0, 0);
    for (int i = 0; i < 400; i++) op(1'($urandom), 4'($urandom_range(0, 10)), $urandom);
    @(negedge clk); rst_n = 1'b0;
    op(0, 4'd1, 0);
    @(negedge clk); rst_n = 1'b1;
    op(1, 4'd4, 32'h2AAA_AAAA);
    for (int i = 0; i < 200; i++) op(1'($urandom), 4'($urandom), $urandom);
    op(0, 4'd1, 0);
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule